// File: doc/BRIEF.md
# Instruction Prefetch Queue with Status

This block is a small first-in first-out store of instruction bytes. It sits between a bus port that delivers 16-bit words and an execution consumer that takes one byte at a time. Whenever at least two byte slots are free, it raises a fetch request for the word at its internal fetch pointer. A word returned in the same cycle as an active request is accepted into the queue. The consumer reads the oldest byte, and it may take a byte in the same cycle that a word arrives.

When the fetch pointer is odd, only the upper byte of the returned word belongs to the instruction stream. That byte alone is stored and the pointer moves forward by one, so every later fetch is word aligned. If the queue is empty, an arriving byte reaches the consumer in that same cycle without passing through storage. A branch flush empties the queue, drops any word returned in the flush cycle and reloads the fetch pointer with the branch target. Each cycle, a registered 2-bit status code reports the queue operation of the previous cycle, so logic outside the block can follow the consumer's position in the stream.

Top module: `prefetch_queue`

## Requirements
- R1: The queue never holds more than DEPTH (default 6) bytes. A word returned while the request is low is not stored.
- R2: `fetchReq` is high exactly when at least two slots are free and `flush` is low. `fetchAddr` shows the current fetch pointer.
- R3: Bytes reach `byteOut` in the order of their addresses, oldest first. Within a word, bit field [7:0] comes before [15:8].
- R4: With the queue empty, an accepted word makes `byteValid` high in the same cycle. `byteOut` is then bits [7:0], or bits [15:8] for an odd pointer.
- R5: In the cycle after an operation, `qStatus` shows a code. 2'b01 means a byte was taken with `takeFirst` high. 2'b11 means a byte was taken with `takeFirst` low. 2'b00 means no operation.
- R6: `flush` empties the queue, ignores `fetchAck` and `takeByte` in its cycle, and loads `fetchAddr` from `flushTarget`. In the next cycle `qStatus` is 2'b10, and this code takes priority over the others.
- R7: An accepted fetch at an odd pointer stores only bits [15:8] and advances the pointer by one. An accepted fetch at an even pointer stores two bytes and advances the pointer by two.
- R8: A byte taken and a word accepted in the same cycle are both honoured. Occupancy then changes by plus two minus one.
- R9: After reset the queue is empty, `fetchAddr` equals RESET_ADDR, `qStatus` is 2'b00 and `fetchReq` is high.
- R10: `takeByte` while `byteValid` is low has no effect. The next `qStatus` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchReq | output | 1 | Request for a word fetch at `fetchAddr` |
| fetchAddr | output | ADDR_W | Current fetch pointer |
| fetchAck | input | 1 | Word on `fetchData` is delivered this cycle |
| fetchData | input | 16 | Fetched word; bits [7:0] are at the even address |
| takeByte | input | 1 | Consumer takes the byte on `byteOut` |
| takeFirst | input | 1 | The taken byte is the first byte of an opcode |
| byteValid | output | 1 | `byteOut` holds an instruction byte |
| byteOut | output | 8 | Oldest available instruction byte |
| flush | input | 1 | Branch: empty the queue and reload the pointer |
| flushTarget | input | ADDR_W | New fetch pointer applied on `flush` |
| qStatus | output | 2 | Status of the previous cycle's queue operation |

## Verification
Several patterns are applied to the queue. Words arrive with no consumer, which separates correct occupancy counting from the request that drops when the queue is full. Words arrive while the consumer takes bytes, which shows whether the plus-two-minus-one update loses or duplicates a byte. Words arrive into an empty queue at both even and odd pointers, which distinguishes the bypass path from stored reads and picks out the wrong half of the word. Flushes are issued with data and a take pending in the same cycle, and takes are issued against an empty queue. Together these show that discarded stimulus leaves no trace in the byte stream, the status codes or the pointer.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // Strobes from the control to the datapath for one clock
  typedef struct packed {
    logic       clear;      // flush: reset pointers, load target
    logic       accept;     // fetched word accepted this clock
    logic       stored;     // queue holds at least one byte
    logic       popStored;  // consumer takes a stored byte
    logic [1:0] wrCount;    // bytes written into storage
    logic       firstHi;    // first written byte comes from bits [15:8]
  } strobe_t;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       fetchAck,
  input  logic       fetchOdd,
  input  logic       takeByte,
  input  logic       takeFirst,
  output logic       fetchReq,
  output logic       byteValid,
  output logic [1:0] qStatus,
  output strobe_t    strb
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic [CW:0]   freeSlots;
  logic          haveStored;
  logic          accept;
  logic          pop;
  logic          skip;
  logic [1:0]    nIn;
  qstat_e        statusQ;
  qstat_e        statusD;

  assign haveStored = (count != '0);
  assign freeSlots  = (CW+1)'(DEPTH) - {1'b0, count};
  assign fetchReq   = !flush && (freeSlots >= (CW+1)'(2));
  assign accept     = fetchReq && fetchAck;
  assign byteValid  = haveStored || accept;
  assign pop        = takeByte && byteValid && !flush;
  assign skip       = pop && !haveStored;
  assign nIn        = accept ? (fetchOdd ? 2'd1 : 2'd2) : 2'd0;

  always_comb begin
    strb           = '0;
    strb.clear     = flush;
    strb.accept    = accept;
    strb.stored    = haveStored;
    strb.popStored = pop && haveStored;
    strb.wrCount   = nIn - {1'b0, skip};
    strb.firstHi   = fetchOdd || skip;
  end

  always_comb begin
    if (flush)    statusD = QS_FLUSH;
    else if (pop) statusD = takeFirst ? QS_FIRST : QS_NEXT;
    else          statusD = QS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      statusQ <= QS_IDLE;
    end else begin
      statusQ <= statusD;
      if (flush) count <= '0;
      else       count <= count + CW'(nIn) - CW'(pop);
    end
  end

  assign qStatus = statusQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> !haveStored); // R6

  AST_TAKE_STATUS: assert property (@(posedge clk) disable iff (rst)
    (takeByte && byteValid && !flush) |=> qStatus[0]); // R5

  AST_EMPTY_TAKE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!flush && !byteValid) |=> (qStatus == 2'b00)); // R10

endmodule

// File: rtl/pq_data.sv
module pq_data
  import pq_pkg::*;
#(
  parameter int              DEPTH      = 6,
  parameter int              ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [15:0]       fetchData,
  input  logic [ADDR_W-1:0] flushTarget,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [7:0]        byteOut
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]        mem [DEPTH];
  logic [PW-1:0]     rdPtr;
  logic [PW-1:0]     wrPtr;
  logic [PW-1:0]     wrPtrNext1;
  logic [7:0]        loByte;
  logic [7:0]        hiByte;
  logic [7:0]        firstByte;
  logic              odd;

  function automatic logic [PW-1:0] wrapAdd(input logic [PW-1:0] p, input logic [1:0] n);
    logic [PW+1:0] s;
    s = {2'b00, p} + {{PW{1'b0}}, n};
    if (s >= (PW+2)'(DEPTH)) s = s - (PW+2)'(DEPTH);
    return s[PW-1:0];
  endfunction

  assign loByte     = fetchData[7:0];
  assign hiByte     = fetchData[15:8];
  assign odd        = fetchAddr[0];
  assign firstByte  = strb.firstHi ? hiByte : loByte;
  assign wrPtrNext1 = wrapAdd(wrPtr, 2'd1);

  // Stored byte when present, otherwise the arriving byte passes straight through
  assign byteOut = strb.stored ? mem[rdPtr] : (odd ? hiByte : loByte);

  always_ff @(posedge clk) begin
    if (!rst && !strb.clear) begin
      if (strb.wrCount != 2'd0) mem[wrPtr] <= firstByte;
      if (strb.wrCount == 2'd2) mem[wrPtrNext1] <= hiByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      fetchAddr <= RESET_ADDR;
    end else if (strb.clear) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      fetchAddr <= flushTarget;
    end else begin
      wrPtr <= wrapAdd(wrPtr, strb.wrCount);
      if (strb.popStored) rdPtr <= wrapAdd(rdPtr, 2'd1);
      if (strb.accept)    fetchAddr <= fetchAddr + (odd ? ADDR_W'(1) : ADDR_W'(2));
    end
  end

  AST_ALIGNED_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    (strb.accept && !strb.clear) |=> !fetchAddr[0]); // R7

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!strb.accept && !strb.clear) |=> $stable(fetchAddr)); // R7

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int                DEPTH      = 6,
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic [15:0]       fetchData,
  input  logic              takeByte,
  input  logic              takeFirst,
  output logic              byteValid,
  output logic [7:0]        byteOut,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flushTarget,
  output logic [1:0]        qStatus
);

  strobe_t strb;

  pq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fetchAck  (fetchAck),
    .fetchOdd  (fetchAddr[0]),
    .takeByte  (takeByte),
    .takeFirst (takeFirst),
    .fetchReq  (fetchReq),
    .byteValid (byteValid),
    .qStatus   (qStatus),
    .strb      (strb)
  );

  pq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_data (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .fetchData   (fetchData),
    .flushTarget (flushTarget),
    .fetchAddr   (fetchAddr),
    .byteOut     (byteOut)
  );

endmodule

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  typedef struct packed {
    logic          fl;
    logic [AW-1:0] tgt;
    logic          ack;
    logic [15:0]   data;
    logic          take;
    logic          first;
    logic          eReq;
    logic [AW-1:0] eAddr;
    logic          eValid;
    logic [7:0]    eByte;
    logic [1:0]    eStat;
  } vec_t;

  localparam int NV = 21;
  // fl tgt ack data take first | req addr valid byte status-next
  localparam vec_t VEC [NV] = '{
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 20'h000, 1'b0, 8'h00, 2'b00}, // R9 idle
    '{1'b0, 20'h0, 1'b1, 16'hB2A1, 1'b0, 1'b0, 1'b1, 20'h000, 1'b1, 8'hA1, 2'b00}, // R4 bypass
    '{1'b0, 20'h0, 1'b1, 16'hD4C3, 1'b1, 1'b1, 1'b1, 20'h002, 1'b1, 8'hA1, 2'b01}, // R8 R5
    '{1'b0, 20'h0, 1'b1, 16'hF6E5, 1'b1, 1'b0, 1'b1, 20'h004, 1'b1, 8'hB2, 2'b11}, // R3 R5
    '{1'b0, 20'h0, 1'b1, 16'h1807, 1'b0, 1'b0, 1'b1, 20'h006, 1'b1, 8'hC3, 2'b00}, // R2 fill
    '{1'b0, 20'h0, 1'b1, 16'h3A29, 1'b0, 1'b0, 1'b0, 20'h008, 1'b1, 8'hC3, 2'b00}, // R1 full
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 20'h008, 1'b1, 8'hC3, 2'b01}, // R3
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 20'h008, 1'b1, 8'hD4, 2'b11}, // R2 one free
    '{1'b0, 20'h0, 1'b1, 16'h5B4A, 1'b1, 1'b0, 1'b1, 20'h008, 1'b1, 8'hE5, 2'b11}, // R8
    '{1'b1, 20'h105, 1'b1, 16'h7D6C, 1'b1, 1'b1, 1'b0, 20'h00A, 1'b1, 8'hF6, 2'b10}, // R6
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 20'h105, 1'b0, 8'h00, 2'b00}, // R6 empty
    '{1'b0, 20'h0, 1'b1, 16'h9F8E, 1'b1, 1'b1, 1'b1, 20'h105, 1'b1, 8'h9F, 2'b01}, // R7 R4 odd
    '{1'b0, 20'h0, 1'b1, 16'h2B1A, 1'b0, 1'b0, 1'b1, 20'h106, 1'b1, 8'h1A, 2'b00}, // R7 aligned
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 20'h108, 1'b1, 8'h1A, 2'b01}, // R3
    '{1'b1, 20'h203, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 20'h108, 1'b1, 8'h2B, 2'b10}, // R6
    '{1'b0, 20'h0, 1'b1, 16'h4433, 1'b0, 1'b0, 1'b1, 20'h203, 1'b1, 8'h44, 2'b00}, // R7 odd store
    '{1'b0, 20'h0, 1'b1, 16'h6655, 1'b1, 1'b1, 1'b1, 20'h204, 1'b1, 8'h44, 2'b01}, // R8
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 20'h206, 1'b1, 8'h55, 2'b11}, // R3
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 20'h206, 1'b1, 8'h66, 2'b11}, // R3
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 20'h206, 1'b0, 8'h00, 2'b00}, // R3 drained
    '{1'b0, 20'h0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 20'h206, 1'b0, 8'h00, 2'b00}  // R10
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          fetchReq;
  logic [AW-1:0] fetchAddr;
  logic          fetchAck;
  logic [15:0]   fetchData;
  logic          takeByte;
  logic          takeFirst;
  logic          byteValid;
  logic [7:0]    byteOut;
  logic          flush;
  logic [AW-1:0] flushTarget;
  logic [1:0]    qStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  prefetch_queue #(.DEPTH(6), .ADDR_W(AW), .RESET_ADDR(20'h0)) uut (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchAck(fetchAck), .fetchData(fetchData), .takeByte(takeByte),
    .takeFirst(takeFirst), .byteValid(byteValid), .byteOut(byteOut),
    .flush(flush), .flushTarget(flushTarget), .qStatus(qStatus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    fetchAck = 1'b0; fetchData = '0; takeByte = 1'b0; takeFirst = 1'b0;
    flush = 1'b0; flushTarget = '0;
  endtask

  task automatic checkResetState(input string when);
    check({"R9 valid ", when}, 32'(byteValid), 32'd0);
    check({"R9 addr ", when}, 32'(fetchAddr), 32'h0);
    check({"R9 status ", when}, 32'(qStatus), 32'd0);
    check({"R9 req ", when}, 32'(fetchReq), 32'd1);
  endtask

  initial begin
    idleInputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checkResetState("start");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check($sformatf("R5/R6 status v%0d", i-1), 32'(qStatus), 32'(VEC[i-1].eStat));
      flush = VEC[i].fl; flushTarget = VEC[i].tgt; fetchAck = VEC[i].ack;
      fetchData = VEC[i].data; takeByte = VEC[i].take; takeFirst = VEC[i].first;
      #1;
      check($sformatf("R2 req v%0d", i), 32'(fetchReq), 32'(VEC[i].eReq));
      check($sformatf("R2/R7 addr v%0d", i), 32'(fetchAddr), 32'(VEC[i].eAddr));
      check($sformatf("R4/R1 valid v%0d", i), 32'(byteValid), 32'(VEC[i].eValid));
      if (VEC[i].eValid)
        check($sformatf("R3/R4 byte v%0d", i), 32'(byteOut), 32'(VEC[i].eByte));
    end
    @(negedge clk);
    check("R10 status last", 32'(qStatus), 32'(VEC[NV-1].eStat));
    idleInputs();

    // R8: even fill while taking, queue contents checked in order
    @(negedge clk);
    fetchAck = 1'b1; fetchData = 16'h2211; #1;
    @(negedge clk); fetchData = 16'h4433; takeByte = 1'b1; #1;
    check("R8 take during write byte", 32'(byteOut), 32'h11);
    @(negedge clk); fetchAck = 1'b0; #1;
    check("R8 second byte", 32'(byteOut), 32'h22);
    check("R8 status", 32'(qStatus), 32'(2'b11));
    @(negedge clk); #1;
    check("R8 third byte", 32'(byteOut), 32'h33);
    takeByte = 1'b0;

    // R9: reset in mid run with bytes held
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; #1;
    checkResetState("midrun");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule